// File: doc/BRIEF.md
# Receive/Transmit Interrupt Aggregator

This block gathers interrupt sources from four serial channels, each holding two receivers and one transmitter, and merges them into one registered host interrupt request. Receivers report through active-low data-ready lines that the block inverts. A receiver source stays asserted for as long as its line stays low, which lasts until the host has read the received word. Transmitters report through a transmitter-ready line. Each rising edge of that line latches a sticky pending bit, and software clears the bit by writing one to it.

Every receiver has its own enable bit, and so does every transmitter. A master enable gates the final request. A software force bit raises the request with no source active, for bring-up and tests. Software reads the raw receiver state, the raw transmitter state and the pending bits for polling. During an interrupt acknowledge the read bus returns a programmable 8-bit vector.

Access goes through a small register port: a 3-bit address, a write strobe with write data, and a combinational read bus. The host interrupt `irq` is a flop output, and it follows its sources by one clock.

Top module: `irq_aggregator`

## Requirements
- R1: Reading address 4 returns the active-high receiver state: bit i is the inverse of `rx_ready_n[i]`, where receiver i belongs to channel i/2 as receiver i%2.
- R2: When master enable is set and the mask bit of receiver i is 1, `irq` is high on the clock after `rx_ready_n[i]` goes low, and stays high while that line stays low.
- R3: The receiver mask sits at address 0, bit i for receiver i. A mask bit of 0 keeps that receiver from affecting `irq`. All mask bits reset to 0.
- R4: A rising edge on `tx_ready[c]` sets the pending bit c, seen at address 5 bit 4+c on the clock after the edge. A falling edge or a steady level never sets it.
- R5: Writing 1 to address 5 bit 4+c clears pending bit c, and writing 0 leaves it unchanged. If a rising edge arrives in the same cycle as the clear, the bit stays set.
- R6: The transmit enables sit at address 2, bit c for channel c. Pending bit c drives `irq` only while its enable is 1. All enables reset to 0.
- R7: Force is address 1 bit 1. With master enable set, force at 1 holds `irq` high with no source active, and clearing it to 0 removes that request.
- R8: Master enable is address 1 bit 0. While it is 0, `irq` is low whatever the sources and force are.
- R9: While `iack` is high, `rdata` returns the vector register. The vector is written and read at address 3 and resets to 0x00.
- R10: After reset, `irq` is low and every pending bit is 0.
- R11: Reading address 5 bits 3:0 returns the raw `tx_ready` levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_ready_n | input | 8 | Receiver data-ready lines, active low |
| tx_ready | input | 4 | Transmitter-ready lines, one per channel |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| iack | input | 1 | Interrupt acknowledge; selects the vector on `rdata` |
| rdata | output | 8 | Read data, combinational |
| irq | output | 1 | Host interrupt request, registered |

## Verification
A transmitter's rising edge and a software write-one-to-clear of the same pending bit can land in the same clock cycle. The bench provokes this directly by raising `tx_ready` in the very cycle that it strobes the clear. A read of the status afterwards must show the bit still set, and a second clear must then remove it. Random stimulus also interleaves receiver changes, enable writes and clears. After each step the bench compares `irq` and the status registers with its own model.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NCH        = 4,
  parameter int RX_PER_CH  = 2,
  parameter int DW         = 8,
  parameter logic [7:0] VEC_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*RX_PER_CH-1:0] rx_ready_n,
  input  logic [NCH-1:0]    tx_ready,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wdata,
  input  logic              iack,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  localparam int NRX = NCH * RX_PER_CH;
  localparam logic [2:0] A_RXMASK = 3'd0;
  localparam logic [2:0] A_CTRL   = 3'd1;
  localparam logic [2:0] A_TXEN   = 3'd2;
  localparam logic [2:0] A_VEC    = 3'd3;
  localparam logic [2:0] A_RXST   = 3'd4;
  localparam logic [2:0] A_TXST   = 3'd5;

  logic [NRX-1:0] rx_mask;
  logic [NCH-1:0] tx_en;
  logic [NCH-1:0] tx_pend;
  logic [NCH-1:0] tx_q;
  logic [DW-1:0]  vector_q;
  logic           master_en;
  logic           force_en;

  wire [NRX-1:0] rx_act  = ~rx_ready_n;
  wire [NCH-1:0] tx_rise = tx_ready & ~tx_q;
  wire           wr_txst = wr_en && (addr == A_TXST);
  wire [NCH-1:0] tx_clr  = wr_txst ? wdata[2*NCH-1:NCH] : '0;
  wire           any_src = |(rx_act & rx_mask) | |(tx_pend & tx_en) | force_en;

  always_ff @(posedge clk) tx_q <= tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_mask   <= '0;
      tx_en     <= '0;
      master_en <= 1'b0;
      force_en  <= 1'b0;
      vector_q  <= VEC_RESET;
    end else if (wr_en) begin
      case (addr)
        A_RXMASK: rx_mask <= wdata[NRX-1:0];
        A_CTRL:   {force_en, master_en} <= wdata[1:0];
        A_TXEN:   tx_en <= wdata[NCH-1:0];
        A_VEC:    vector_q <= wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_pend <= '0;
    else        tx_pend <= (tx_pend & ~tx_clr) | tx_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= master_en & any_src;
  end

  always_comb begin
    rdata = '0;
    if (iack) rdata = vector_q;
    else begin
      case (addr)
        A_RXMASK: rdata[NRX-1:0] = rx_mask;
        A_CTRL:   rdata[1:0] = {force_en, master_en};
        A_TXEN:   rdata[NCH-1:0] = tx_en;
        A_VEC:    rdata = vector_q;
        A_RXST:   rdata[NRX-1:0] = rx_act;
        A_TXST: begin
          rdata[NCH-1:0]     = tx_ready;
          rdata[2*NCH-1:NCH] = tx_pend;
        end
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int NCH = 4,
  parameter int NRX = 8,
  parameter int DW  = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NRX-1:0] rx_ready_n,
  input logic [NRX-1:0] rx_mask,
  input logic [NCH-1:0] tx_ready,
  input logic [NCH-1:0] tx_pend,
  input logic           master_en,
  input logic           force_en,
  input logic           iack,
  input logic [DW-1:0]  rdata,
  input logic [DW-1:0]  vector_q,
  input logic           irq
);
  a_r2_rx_level: assert property (@(posedge clk) disable iff (!rst_n)
    master_en && ((rx_mask & ~rx_ready_n) != '0) |=> irq);

  a_r7_force_raises: assert property (@(posedge clk) disable iff (!rst_n)
    master_en && force_en |=> irq);

  a_r8_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> !irq);

  a_r9_ack_vector: assert property (@(posedge clk) disable iff (!rst_n)
    iack |-> rdata == vector_q);

  for (genvar c = 0; c < NCH; c++) begin : g_tx
    a_r5_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_ready[c]) |=> tx_pend[c]);
    a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_pend[c] && !$rose(tx_ready[c]) |=> !tx_pend[c]);
  end
endmodule

bind irq_aggregator irq_aggregator_chk #(.NCH(NCH), .NRX(NRX), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_ready_n(rx_ready_n), .rx_mask(rx_mask),
  .tx_ready(tx_ready), .tx_pend(tx_pend), .master_en(master_en),
  .force_en(force_en), .iack(iack), .rdata(rdata), .vector_q(vector_q),
  .irq(irq));

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rx_ready_n = 8'hFF;
  logic [3:0] tx_ready = 4'h0;
  logic [2:0] addr = 3'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       iack = 1'b0;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [7:0] m_mask = 0;
  logic       m_master = 0, m_force = 0;
  logic [3:0] m_txen = 0, m_pend = 0;
  logic [7:0] m_vec = 0;

  irq_aggregator dut (.clk(clk), .rst_n(rst_n), .rx_ready_n(rx_ready_n),
    .tx_ready(tx_ready), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .iack(iack), .rdata(rdata), .irq(irq));

  always #4 clk = ~clk;

  function automatic logic exp_irq();
    return m_master & (m_force | |(~rx_ready_n & m_mask) | |(m_pend & m_txen));
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    case (a)
      3'd0: m_mask = d;
      3'd1: {m_force, m_master} = d[1:0];
      3'd2: m_txen = d[3:0];
      3'd3: m_vec = d;
      3'd5: m_pend = m_pend & ~d[7:4];
      default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_tx(logic [3:0] v);
    @(negedge clk);
    m_pend = m_pend | (v & ~tx_ready);
    tx_ready = v;
  endtask

  task automatic settle();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 irq after reset", {7'd0, irq}, 8'd0);
    rd(3'd5, d); check("R10 pending after reset", {4'd0, d[7:4]}, 8'd0);
    rd(3'd0, d); check("R3 mask reset", d, 8'd0);
    rd(3'd2, d); check("R6 txen reset", d, 8'd0);
    iack = 1'b1; #1 check("R9 vector reset", rdata, 8'h00); iack = 1'b0;

    wr(3'd1, 8'h01);
    @(negedge clk); rx_ready_n = 8'hFB;
    settle();
    check("R3 masked receiver", {7'd0, irq}, 8'd0);
    rd(3'd4, d); check("R1 rx status", d, 8'h04);
    wr(3'd0, 8'h04);
    @(posedge clk); @(negedge clk);
    check("R2 irq one clock after mask", {7'd0, irq}, 8'd1);
    @(negedge clk); rx_ready_n = 8'hFF;
    @(posedge clk); @(negedge clk);
    check("R2 irq drops with level", {7'd0, irq}, 8'd0);
    @(negedge clk); rx_ready_n = 8'hFB;
    @(posedge clk); @(negedge clk);
    check("R2 irq one clock after line low", {7'd0, irq}, 8'd1);
    @(negedge clk); rx_ready_n = 8'hFF;
    settle();

    set_tx(4'h2);
    @(posedge clk); @(negedge clk);
    rd(3'd5, d); check("R4 rise sets pending", d, 8'h22);
    check("R11 raw tx", {4'd0, d[3:0]}, 8'h02);
    check("R6 pending without enable", {7'd0, irq}, 8'd0);
    wr(3'd2, 8'h02); settle();
    check("R6 enabled pending raises irq", {7'd0, irq}, 8'd1);
    set_tx(4'h0); settle();
    wr(3'd5, 8'h00);
    rd(3'd5, d); check("R5 write zero keeps pending", d, 8'h20);
    wr(3'd5, 8'h20); settle();
    rd(3'd5, d); check("R5 w1c clears", d, 8'h00);
    check("R4 falling edge sets nothing", {7'd0, irq}, 8'd0);

    @(negedge clk);
    tx_ready = 4'h1; wr_en = 1'b1; addr = 3'd5; wdata = 8'h10;
    @(negedge clk); wr_en = 1'b0; m_pend = m_pend | 4'h1;
    rd(3'd5, d); check("R5 set wins over clear", d[7:4], 8'h01);
    wr(3'd5, 8'h10);
    rd(3'd5, d); check("R5 second clear", d[7:4], 8'h00);
    check("R4 steady high no set", {7'd0, irq}, 8'd0);

    wr(3'd1, 8'h03); settle();
    check("R7 force raises irq", {7'd0, irq}, 8'd1);
    wr(3'd1, 8'h01); settle();
    check("R7 force cleared", {7'd0, irq}, 8'd0);
    wr(3'd1, 8'h02); @(negedge clk); rx_ready_n = 8'h00; settle();
    check("R8 master off blocks", {7'd0, irq}, 8'd0);
    @(negedge clk); rx_ready_n = 8'hFF;
    wr(3'd1, 8'h01);

    wr(3'd3, 8'hA5);
    @(negedge clk); iack = 1'b1; #1 check("R9 ack vector", rdata, 8'hA5);
    iack = 1'b0;
    rd(3'd3, d); check("R9 vector readback", d, 8'hA5);

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: begin @(negedge clk); rx_ready_n = 8'($urandom); end
        1: set_tx(4'($urandom));
        2: wr(3'd0, 8'($urandom));
        3: wr(3'd1, 8'($urandom % 4));
        4: wr(3'd2, 8'($urandom % 16));
        default: wr(3'd5, {4'($urandom), 4'd0});
      endcase
      settle();
      check("R2 R6 R7 R8 random irq", {7'd0, irq}, {7'd0, exp_irq()});
      rd(3'd5, d); check("R4 R11 random tx status", d, {m_pend, tx_ready});
      rd(3'd4, d); check("R1 random rx status", d, ~rx_ready_n);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule